// File: doc/BRIEF.md
# Mode-Switched Dual-Role Serial Port

This block is the host-side serial port of a receiver chip. Three serial pins carry two kinds of traffic. While the mode input `cfg_n` is low, the host is the bus master and the block is a slave. The host writes and reads a small internal register file with two-byte frames. Its clock runs at idle-low polarity and it samples read data on the falling edge.

When `cfg_n` is high, the block becomes the master. It divides the system clock to generate the serial clock. It shifts each received data byte, offered on a valid/ready port, out on the pin that carries host write data in the other mode.

The `bus_off` input takes the pins off the bus and leaves the stored registers untouched. The `wake` input must stay high for any transfer, and a low level puts the port in standby. Any of these events in the middle of a byte discards the partial byte. Host clock and data are brought into the system clock domain through a synchronizer. Each output and each output-enable leaves the block from a flip-flop.

Top module: `dual_role_serial_if`

## Requirements
- R1: While `rst` is high, every output (`sck_out`, `sck_oe`, `mosi_out`, `mosi_oe`, `miso_out`, `miso_oe`, `rx_ready`) is 0.
- R2: With `cfg_n` low, `wake` high and `bus_off` low, the block is a slave: `miso_oe` is 1, `sck_oe` and `mosi_oe` are 0, and `rx_ready` is 0.
- R3: With `bus_off` high, `sck_oe`, `mosi_oe` and `miso_oe` are 0 within two clocks, and register contents are kept.
- R4: A write frame is a command byte with bit 7 = 0 and the register address in bits 3:0, followed by a data byte. Both bytes are MSB first, and each `mosi_in` bit is taken at a falling `sck_in` edge. After the frame, the addressed register holds the data byte.
- R5: A read frame is a command byte with bit 7 = 1 and the address in bits 3:0. During the following byte, `miso_out` gives the register value MSB first. Each bit is launched after a rising `sck_in` edge and is valid at the next falling edge.
- R6: With `cfg_n` high, `wake` high and `bus_off` low, `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0. While no byte is being sent, `sck_out` and `mosi_out` are 0.
- R7: In receive mode, a byte is taken from `rx_data` only at a clock edge where both `rx_valid` and `rx_ready` are high. `rx_ready` is high only while the shifter is idle. The byte appears on `mosi_out` MSB first, one bit per rising `sck_out` edge. The rising edges within a byte are 2*SCK_DIV clocks apart, and a byte held on the port during a transfer does not disturb the byte in flight.
- R8: With `wake` low, all three enables are 0 within two clocks. A transfer in progress is abandoned, and no further `sck_out` edges come from it.
- R9: A low `wake`, a high `bus_off` or a change of mode in the middle of a byte discards the partial byte and returns the bit position to zero, so the next frame is decoded from its first bit.
- R10: Register contents survive mode changes, bus release and standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_n | input | 1 | Mode select: low = host configures, high = receive output |
| bus_off | input | 1 | High releases all serial pins, state kept |
| wake | input | 1 | High = operating, low = standby |
| sck_in | input | 1 | Serial clock from host (configuration mode) |
| sck_out | output | 1 | Generated serial clock (receive mode) |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| mosi_in | input | 1 | Host write data (configuration mode) |
| mosi_out | output | 1 | Received data out (receive mode) |
| mosi_oe | output | 1 | Drive enable for the MOSI pin |
| miso_out | output | 1 | Register read data to host |
| miso_oe | output | 1 | Drive enable for the MISO pin |
| rx_data | input | 8 | Received byte offered for output |
| rx_valid | input | 1 | `rx_data` is valid |
| rx_ready | output | 1 | Shifter idle, byte will be taken |

## Verification
Two events can land on the same clock. The first pair is the edge that completes a byte and an abort from `bus_off`, `wake` or the mode pin. The bench drops `bus_off`, `wake` and `cfg_n` part way through configuration bytes and receive bytes. After each drop it checks that the enables go quiet. It then checks that a fresh frame is decoded from its first bit, judged by reading back register values. The second pair is the end of a receive byte and the acceptance of the next one. The bench holds `rx_valid` high across a whole byte so that the next acceptance coincides with the last bit. It then compares the 16 captured bits with both bytes in order. Random register writes and reads from a fixed seed are mixed in, and the results are checked against a bench-side model of the register file.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } frame_ph_t;
endpackage

// File: rtl/dsi_edge_sync.sv
module dsi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic mosi_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  logic [STAGES:0]   sck_pipe;
  logic [STAGES-1:0] mosi_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_pipe  <= '0;
      mosi_pipe <= '0;
    end else begin
      sck_pipe  <= {sck_pipe[STAGES-1:0], sck_in};
      mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi_in};
    end
  end

  assign sck_rise = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
  assign sck_fall = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
  assign mosi_s   = mosi_pipe[STAGES-1];
endmodule

// File: rtl/dsi_regfile.sv
module dsi_regfile #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dsi_cfg_slave.sv
module dsi_cfg_slave
  import dsi_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic sck_rise,
  input  logic sck_fall,
  input  logic mosi_bit,
  output logic miso_bit
);
  logic [2:0]           bit_cnt;
  logic [BYTE_BITS-2:0] sh;
  frame_ph_t            ph;
  logic                 cmd_rd;
  logic [AW-1:0]        cmd_addr;
  logic [BYTE_BITS-1:0] tx_sh;
  logic                 we, re, ld;
  logic [BYTE_BITS-1:0] wdata;
  logic [BYTE_BITS-1:0] rdata;

  dsi_regfile #(.DW(BYTE_BITS), .DEPTH(DEPTH)) u_regs (
    .clk   (clk),
    .we    (we),
    .waddr (cmd_addr),
    .wdata (wdata),
    .re    (re),
    .raddr (cmd_addr),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      bit_cnt  <= '0;
      sh       <= '0;
      ph       <= PH_CMD;
      cmd_rd   <= 1'b0;
      cmd_addr <= '0;
      tx_sh    <= '0;
      miso_bit <= 1'b0;
      we       <= 1'b0;
      re       <= 1'b0;
      ld       <= 1'b0;
      wdata    <= '0;
    end else begin
      we <= 1'b0;
      re <= 1'b0;
      ld <= re;
      if (ld) tx_sh <= rdata;
      if (sck_fall) begin
        sh      <= {sh[BYTE_BITS-3:0], mosi_bit};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (ph == PH_CMD) begin
            cmd_rd   <= sh[BYTE_BITS-2];
            cmd_addr <= {sh[AW-2:0], mosi_bit};
            re       <= sh[BYTE_BITS-2];
            ph       <= PH_DATA;
          end else begin
            we    <= ~cmd_rd;
            wdata <= {sh, mosi_bit};
            ph    <= PH_CMD;
          end
        end
      end
      if (sck_rise) begin
        if (ph == PH_DATA && cmd_rd) begin
          miso_bit <= tx_sh[BYTE_BITS-1];
          tx_sh    <= {tx_sh[BYTE_BITS-2:0], 1'b0};
        end else begin
          miso_bit <= 1'b0;
        end
      end
    end
  end

  // R9
  cfg_bitcnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (bit_cnt == 3'd0));

  // R4
  cfg_write_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> $past(sck_fall));
endmodule

// File: rtl/dsi_rx_master.sv
module dsi_rx_master
  import dsi_pkg::*;
#(
  parameter int SCK_DIV = 4,
  localparam int CW     = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic [BYTE_BITS-1:0] rx_data,
  input  logic                 rx_valid,
  output logic                 rx_ready,
  output logic                 sck_o,
  output logic                 mosi_o
);
  localparam logic [CW-1:0] LAST = CW'(SCK_DIV - 1);

  logic                 busy, half;
  logic [2:0]           bit_cnt;
  logic [CW-1:0]        div_cnt;
  logic [BYTE_BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      busy     <= 1'b0;
      half     <= 1'b0;
      bit_cnt  <= '0;
      div_cnt  <= '0;
      sh       <= '0;
      rx_ready <= 1'b0;
    end else if (!busy) begin
      if (rx_ready && rx_valid) begin
        busy     <= 1'b1;
        rx_ready <= 1'b0;
        sh       <= rx_data;
        div_cnt  <= '0;
        half     <= 1'b0;
        bit_cnt  <= '0;
      end else begin
        rx_ready <= 1'b1;
      end
    end else if (div_cnt == LAST) begin
      div_cnt <= '0;
      half    <= ~half;
      if (half) begin
        sh      <= {sh[BYTE_BITS-2:0], 1'b0};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          busy     <= 1'b0;
          rx_ready <= 1'b1;
        end
      end
    end else begin
      div_cnt <= div_cnt + CW'(1);
    end
  end

  assign sck_o  = busy & half;
  assign mosi_o = busy & sh[BYTE_BITS-1];

  // R7
  rx_idle_counters_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (bit_cnt == 3'd0 && !half));

  // R7
  rx_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_ready) && $past(active)) |-> $past(rx_valid));
endmodule

// File: rtl/dual_role_serial_if.sv
module dual_role_serial_if
  import dsi_pkg::*;
#(
  parameter int SCK_DIV     = 4,
  parameter int REG_DEPTH   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_n,
  input  logic                 bus_off,
  input  logic                 wake,
  input  logic                 sck_in,
  output logic                 sck_out,
  output logic                 sck_oe,
  input  logic                 mosi_in,
  output logic                 mosi_out,
  output logic                 mosi_oe,
  output logic                 miso_out,
  output logic                 miso_oe,
  input  logic [BYTE_BITS-1:0] rx_data,
  input  logic                 rx_valid,
  output logic                 rx_ready
);
  logic cfg_act, rx_act;
  logic sck_rise, sck_fall, mosi_s;
  logic cfg_miso, rx_sck, rx_mosi;

  assign cfg_act = wake & ~bus_off & ~cfg_n;
  assign rx_act  = wake & ~bus_off & cfg_n;

  dsi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sck_in   (sck_in),
    .mosi_in  (mosi_in),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s)
  );

  dsi_cfg_slave #(.DEPTH(REG_DEPTH)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .active   (cfg_act),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_bit (mosi_s),
    .miso_bit (cfg_miso)
  );

  dsi_rx_master #(.SCK_DIV(SCK_DIV)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .active   (rx_act),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .sck_o    (rx_sck),
    .mosi_o   (rx_mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_out  <= 1'b0;
      sck_oe   <= 1'b0;
      mosi_out <= 1'b0;
      mosi_oe  <= 1'b0;
      miso_out <= 1'b0;
      miso_oe  <= 1'b0;
    end else begin
      sck_oe   <= rx_act;
      mosi_oe  <= rx_act;
      miso_oe  <= cfg_act;
      sck_out  <= rx_sck & rx_act;
      mosi_out <= rx_mosi & rx_act;
      miso_out <= cfg_miso & cfg_act;
    end
  end

  // R3
  bus_release_chk: assert property (@(posedge clk) disable iff (rst)
    bus_off |=> (!sck_oe && !mosi_oe && !miso_oe));

  // R8
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wake |=> (!sck_oe && !mosi_oe && !miso_oe && !sck_out));

  // R6
  single_driver_chk: assert property (@(posedge clk) disable iff (rst)
    !(sck_oe && miso_oe));

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && $past(rx_ready) && $past(rx_act)) |-> (!sck_out && !mosi_out));
endmodule

// File: tb/dual_role_serial_if_bench.sv
module dual_role_serial_if_bench;
  localparam int DIV  = 4;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_n = 1'b0, bus_off = 1'b0, wake = 1'b1;
  logic sck_in = 1'b0, mosi_in = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, rx_ready;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  logic [7:0] model [16];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  dual_role_serial_if #(.SCK_DIV(DIV)) u_dual_role_serial_if (
    .clk(clk), .rst(rst), .cfg_n(cfg_n), .bus_off(bus_off), .wake(wake),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_out(miso_out), .miso_oe(miso_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd_byte(input bit rd, input logic [3:0] a);
    return {rd, 3'b000, a};
  endfunction

  task automatic host_byte(input logic [7:0] tx, output logic [7:0] rx);
    logic [7:0] r;
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sck_in = 1'b1;
      mosi_in = tx[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso_out;
      sck_in = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    rx = r;
  endtask

  task automatic host_bits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      sck_in = 1'b1;
      mosi_in = tx[i];
      repeat (HALF) @(negedge clk);
      sck_in = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    host_byte(cmd_byte(1'b0, a), dummy);
    host_byte(d, dummy);
    model[a] = d;
  endtask

  task automatic host_read_chk(input logic [3:0] a, input string tag);
    logic [7:0] dummy, got;
    host_byte(cmd_byte(1'b1, a), dummy);
    host_byte(8'h00, got);
    chk(got === model[a], tag, int'(got), int'(model[a]));
  endtask

  task automatic offer(input logic [7:0] b);
    rx_data = b;
    rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic capture(input int n, input int limit, output logic [15:0] bits,
                         output int rises, output bit per_ok);
    int last, guard;
    logic prev;
    last = -1; guard = 0; prev = sck_out; bits = '0; rises = 0; per_ok = 1'b1;
    while (rises < n && guard < limit) begin
      @(negedge clk);
      guard++;
      if (sck_out && !prev) begin
        bits = {bits[14:0], mosi_out};
        if (last >= 0 && (rises % 8) != 0 && (cyc - last) != 2 * DIV) per_ok = 1'b0;
        last = cyc;
        rises++;
      end
      prev = sck_out;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] bits;
    int rises;
    bit per_ok;
    logic [3:0] a;
    logic [7:0] d;
    void'($urandom(32'd5150));

    repeat (5) @(negedge clk);
    // R1: all outputs low during reset
    chk({sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, rx_ready} == 7'b0,
        "R1 reset outputs", int'({sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, rx_ready}), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R2: slave role enables
    chk(miso_oe && !sck_oe && !mosi_oe && !rx_ready, "R2 config enables",
        int'({miso_oe, sck_oe, mosi_oe, rx_ready}), 8);

    // R4: directed writes of every register
    for (int i = 0; i < 16; i++) host_write(4'(i), 8'(i * 37 + 5));
    // R5: read back corners
    host_read_chk(4'd0, "R5 read addr 0");
    host_read_chk(4'd15, "R5 read addr 15");
    host_write(4'd7, 8'hA5);
    host_read_chk(4'd7, "R4 write A5");
    host_write(4'd7, 8'h5A);
    host_read_chk(4'd7, "R4 overwrite 5A");

    // R3: bus release keeps registers
    @(negedge clk); bus_off = 1'b1;
    repeat (2) @(negedge clk);
    chk(!miso_oe && !sck_oe && !mosi_oe, "R3 bus release enables",
        int'({miso_oe, sck_oe, mosi_oe}), 0);
    repeat (10) @(negedge clk); bus_off = 1'b0;
    repeat (3) @(negedge clk);
    host_read_chk(4'd3, "R3 contents kept after release");

    // R9: partial command then bus release, next frame aligned
    host_bits(8'h8F, 3);
    bus_off = 1'b1; repeat (6) @(negedge clk); bus_off = 1'b0; repeat (3) @(negedge clk);
    host_write(4'd9, 8'hC3);
    host_read_chk(4'd9, "R9 frame after bus release");
    // R9: partial data byte then mode flip
    host_bits(cmd_byte(1'b0, 4'd2), 8);
    host_bits(8'hFF, 5);
    cfg_n = 1'b1; repeat (6) @(negedge clk); cfg_n = 1'b0; repeat (3) @(negedge clk);
    host_read_chk(4'd2, "R9 aborted write left register");
    // R9: partial byte then standby
    host_bits(8'hF0, 6);
    wake = 1'b0; repeat (6) @(negedge clk); wake = 1'b1; repeat (3) @(negedge clk);
    host_write(4'd11, 8'h3C);
    host_read_chk(4'd11, "R9 frame after standby");

    // random writes and reads
    for (int k = 0; k < 24; k++) begin
      a = 4'($urandom);
      d = 8'($urandom);
      if ($urandom % 2) host_write(a, d);
      host_read_chk(4'($urandom), "R5 random read");
    end

    // R6: receive mode enables and idle levels
    @(negedge clk); cfg_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sck_oe && mosi_oe && !miso_oe, "R6 receive enables", int'({sck_oe, mosi_oe, miso_oe}), 6);
    chk(!sck_out && !mosi_out && rx_ready, "R6 idle low", int'({sck_out, mosi_out, rx_ready}), 1);

    // R7: single byte, order and period
    fork
      offer(8'hB4);
      capture(8, 400, bits, rises, per_ok);
    join
    chk(bits[7:0] == 8'hB4 && rises == 8, "R7 byte B4", int'(bits[7:0]), 8'hB4);
    chk(per_ok, "R7 sck period", 0, 2 * DIV);
    repeat (4) @(negedge clk);
    chk(!sck_out && !mosi_out && rx_ready, "R6 idle after byte", int'({sck_out, mosi_out, rx_ready}), 1);

    // R7: back-to-back, second byte held during first
    fork
      begin
        rx_data = 8'h81; rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_data = 8'h7E;
        do @(negedge clk); while (!rx_ready);
        @(negedge clk);
        rx_valid = 1'b0;
      end
      capture(16, 800, bits, rises, per_ok);
    join
    chk(bits == 16'h817E, "R7 back-to-back order", int'(bits), 16'h817E);

    // random receive bytes
    for (int k = 0; k < 6; k++) begin
      d = 8'($urandom);
      fork
        offer(d);
        capture(8, 400, bits, rises, per_ok);
      join
      chk(bits[7:0] == d && per_ok, "R7 random byte", int'(bits[7:0]), int'(d));
    end

    // R8: standby in the middle of a byte
    fork
      offer(8'hFF);
      capture(3, 400, bits, rises, per_ok);
    join
    @(negedge clk); wake = 1'b0;
    repeat (2) @(negedge clk);
    chk(!sck_oe && !mosi_oe && !miso_oe && !sck_out, "R8 standby quiet",
        int'({sck_oe, mosi_oe, miso_oe, sck_out}), 0);
    repeat (5) @(negedge clk); wake = 1'b1;
    capture(1, 60, bits, rises, per_ok);
    chk(rises == 0, "R8 aborted byte no further clocks", rises, 0);
    chk(rx_ready && !mosi_out, "R9 receive idle after abort", int'({rx_ready, mosi_out}), 2);
    fork
      offer(8'h69);
      capture(8, 400, bits, rises, per_ok);
    join
    chk(bits[7:0] == 8'h69, "R9 full byte after abort", int'(bits[7:0]), 8'h69);

    // R3: release in receive mode
    @(negedge clk); bus_off = 1'b1;
    repeat (2) @(negedge clk);
    chk(!sck_oe && !mosi_oe, "R3 receive release", int'({sck_oe, mosi_oe}), 0);
    bus_off = 1'b0;

    // R10: registers survive mode changes and standby
    @(negedge clk); cfg_n = 1'b0;
    repeat (4) @(negedge clk);
    host_read_chk(4'd9, "R10 kept across modes");
    host_read_chk(4'd7, "R10 kept across modes");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule